// File: doc/BRIEF.md
# Read-Leveling Window Quality Scorer

This block grades one pass/fail vector from a DRAM read-leveling sweep. Each of the 64 bits records whether a single delay tap returned correct data. The block finds the most plausible passing window, which is the longest unbroken run of ones. It reports where that window starts, how wide it is, and an error score. A later stage uses the score to pick the most trustworthy of several repeated measurements.

A caller pulses `start_i` while the block is idle, supplying the vector and a DRAM generation flag. The flag selects the largest window width that counts as normal. The block then walks the vector one tap per clock, from bit 0 upward. It raises `done_o` for one cycle with the start index, the width and the saturated score. The outputs hold their values until the next result.

Top module: `rl_window_scorer`

## Requirements
- R1: After reset, `done_o`, `busy_o`, `win_start_o`, `win_width_o` and `score_o` are all 0.
- R2: `start_i` is accepted on a rising edge where `busy_o` is 0. `busy_o` is 1 from the next cycle until the result. `done_o` is 1 for exactly one cycle, following the 65th rising edge after the accepting edge.
- R3: While `busy_o` is 1, `start_i`, `mask_i` and `gen_sel_i` are ignored. The result reflects the vector and flag captured at acceptance.
- R4: The window is the longest run of consecutive ones. When runs tie in length, the run at the lower bit index wins. `win_start_o` is the index of the run's lowest bit. `win_width_o` is the run length, capped at 63 (a 64-bit run reports 63).
- R5: An all-zero vector gives `win_start_o`=0, `win_width_o`=0 and `score_o`=100, with no other penalty.
- R6: A non-blank window narrower than 4 adds 6 × (4 − width) to the score.
- R7: Every zero bit between the lowest and the highest set bit of the vector adds 11 to the score.
- R8: The width limit is 7 when `gen_sel_i`=0 and 5 when `gen_sel_i`=1. A window wider than the limit adds 12 once.
- R9: When R7 finds no zero bits and the window exceeds the limit, a further 5 × (width − limit) is added.
- R10: `score_o` is the sum of the penalties, saturated at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to score `mask_i` |
| mask_i | input | 64 | Pass/fail vector, bit n = tap n |
| gen_sel_i | input | 1 | DRAM generation flag; selects the width limit |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle result strobe |
| win_start_o | output | 6 | Lowest tap index of the chosen window |
| win_width_o | output | 6 | Width of the chosen window |
| score_o | output | 8 | Saturated error score |

## Verification
The bench builds the block with its default parameters: a 64-tap vector, a 6-bit range field, an 8-bit score and width limits of 7 and 5. With these values the full-ones vector reaches the width cap. A two-ended sparse vector drives the bubble sum far past the saturation point. A six-wide window lands between the two limits, so `gen_sel_i` alone decides whether the over-long and trailing penalties apply. Random vectors mix isolated runs with noise, so tie-breaking and bubble counting meet many shapes.

// File: rtl/rlq_pkg.sv
package rlq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FIN  = 2'd2
  } scan_state_e;
endpackage

// File: rtl/rlq_run_tracker.sv
module rlq_run_tracker #(
  parameter int MASK_W = 64,
  parameter int IDX_W  = $clog2(MASK_W),
  parameter int LEN_W  = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             bit_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] best_start_o,
  output logic [LEN_W-1:0] best_len_o
);
  logic [LEN_W-1:0] cur_len_q, best_len_q, next_len;
  logic [IDX_W-1:0] cur_start_q, best_start_q;

  assign next_len = cur_len_q + LEN_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_len_q    <= '0;
      cur_start_q  <= '0;
      best_len_q   <= '0;
      best_start_q <= '0;
    end else if (clr_i) begin
      cur_len_q    <= '0;
      cur_start_q  <= '0;
      best_len_q   <= '0;
      best_start_q <= '0;
    end else if (en_i) begin
      if (bit_i) begin
        cur_len_q <= next_len;
        if (cur_len_q == '0) cur_start_q <= idx_i;
        // strict compare keeps the lower-index run on a tie
        if (next_len > best_len_q) begin
          best_len_q   <= next_len;
          best_start_q <= (cur_len_q == '0) ? idx_i : cur_start_q;
        end
      end else begin
        cur_len_q <= '0;
      end
    end
  end

  assign best_start_o = best_start_q;
  assign best_len_o   = best_len_q;

  assert_len_monotonic_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |=> (best_len_q >= $past(best_len_q)));

  assert_window_fits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((LEN_W+1)'(best_start_q) + (LEN_W+1)'(best_len_q)) <= (LEN_W+1)'(MASK_W));
endmodule

// File: rtl/rlq_span_stats.sv
module rlq_span_stats #(
  parameter int MASK_W = 64,
  parameter int IDX_W  = $clog2(MASK_W),
  parameter int LEN_W  = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             bit_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             any_o,
  output logic [IDX_W-1:0] lo_o,
  output logic [IDX_W-1:0] hi_o,
  output logic [LEN_W-1:0] pop_o
);
  logic             any_q;
  logic [IDX_W-1:0] lo_q, hi_q;
  logic [LEN_W-1:0] pop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      any_q <= 1'b0;
      lo_q  <= '0;
      hi_q  <= '0;
      pop_q <= '0;
    end else if (clr_i) begin
      any_q <= 1'b0;
      lo_q  <= '0;
      hi_q  <= '0;
      pop_q <= '0;
    end else if (en_i && bit_i) begin
      any_q <= 1'b1;
      if (!any_q) lo_q <= idx_i;
      hi_q  <= idx_i;
      pop_q <= pop_q + LEN_W'(1);
    end
  end

  assign any_o = any_q;
  assign lo_o  = lo_q;
  assign hi_o  = hi_q;
  assign pop_o = pop_q;

  assert_pop_in_span_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_q |-> (pop_q <= (LEN_W'(hi_q) - LEN_W'(lo_q) + LEN_W'(1))));

  assert_lo_not_above_hi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_q |-> (lo_q <= hi_q));
endmodule

// File: rtl/rlq_score_calc.sv
module rlq_score_calc #(
  parameter int MASK_W     = 64,
  parameter int IDX_W      = $clog2(MASK_W),
  parameter int LEN_W      = IDX_W + 1,
  parameter int RANGE_BITS = 6,
  parameter int SCORE_W    = 8,
  parameter int NARROW_MIN = 4,
  parameter int LIMIT_G0   = 7,
  parameter int LIMIT_G1   = 5,
  parameter int W_BLANK    = 100,
  parameter int W_NARROW   = 6,
  parameter int W_BUBBLE   = 11,
  parameter int W_LONG     = 12,
  parameter int W_TRAIL    = 5
) (
  input  logic                  any_i,
  input  logic [LEN_W-1:0]      best_len_i,
  input  logic [IDX_W-1:0]      lo_i,
  input  logic [IDX_W-1:0]      hi_i,
  input  logic [LEN_W-1:0]      pop_i,
  input  logic                  gen_sel_i,
  output logic [RANGE_BITS-1:0] width_o,
  output logic [SCORE_W-1:0]    score_o
);
  localparam int RANGE_MAX = (1 << RANGE_BITS) - 1;
  localparam int SCORE_MAX = (1 << SCORE_W) - 1;
  localparam int ACC_W     = SCORE_W + LEN_W + 4;

  logic [RANGE_BITS-1:0] width;
  logic [LEN_W-1:0]      bubbles;
  logic [ACC_W-1:0]      acc, lim, wid_a;

  always_comb begin
    if (best_len_i > LEN_W'(RANGE_MAX)) width = RANGE_BITS'(RANGE_MAX);
    else                                width = RANGE_BITS'(best_len_i);
  end

  assign bubbles = any_i ? (LEN_W'(hi_i) - LEN_W'(lo_i) + LEN_W'(1) - pop_i) : '0;
  assign lim     = gen_sel_i ? ACC_W'(LIMIT_G1) : ACC_W'(LIMIT_G0);
  assign wid_a   = ACC_W'(width);

  always_comb begin
    acc = '0;
    if (!any_i) begin
      acc = ACC_W'(W_BLANK);
    end else begin
      if (wid_a < ACC_W'(NARROW_MIN))
        acc = acc + ACC_W'(W_NARROW) * (ACC_W'(NARROW_MIN) - wid_a);
      acc = acc + ACC_W'(W_BUBBLE) * ACC_W'(bubbles);
      if (wid_a > lim) begin
        acc = acc + ACC_W'(W_LONG);
        if (bubbles == '0) acc = acc + ACC_W'(W_TRAIL) * (wid_a - lim);
      end
    end
  end

  assign width_o = width;
  assign score_o = (acc > ACC_W'(SCORE_MAX)) ? SCORE_W'(SCORE_MAX) : SCORE_W'(acc);
endmodule

// File: rtl/rl_window_scorer.sv
module rl_window_scorer
  import rlq_pkg::*;
#(
  parameter int MASK_W     = 64,
  parameter int RANGE_BITS = 6,
  parameter int SCORE_W    = 8,
  parameter int NARROW_MIN = 4,
  parameter int LIMIT_G0   = 7,
  parameter int LIMIT_G1   = 5,
  parameter int W_BLANK    = 100,
  parameter int W_NARROW   = 6,
  parameter int W_BUBBLE   = 11,
  parameter int W_LONG     = 12,
  parameter int W_TRAIL    = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [MASK_W-1:0]        mask_i,
  input  logic                     gen_sel_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [$clog2(MASK_W)-1:0] win_start_o,
  output logic [RANGE_BITS-1:0]    win_width_o,
  output logic [SCORE_W-1:0]       score_o
);
  localparam int IDX_W = $clog2(MASK_W);
  localparam int LEN_W = IDX_W + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MASK_W - 1);

  scan_state_e          state_q;
  logic [IDX_W-1:0]     cnt_q;
  logic [MASK_W-1:0]    mask_q;
  logic                 gen_q, done_q;
  logic [IDX_W-1:0]     start_q;
  logic [RANGE_BITS-1:0] width_q;
  logic [SCORE_W-1:0]   score_q;

  logic                 clr, en;
  logic [IDX_W-1:0]     best_start, lo, hi;
  logic [LEN_W-1:0]     best_len, pop;
  logic                 any;
  logic [RANGE_BITS-1:0] calc_width;
  logic [SCORE_W-1:0]   calc_score;

  assign clr = (state_q == ST_IDLE) && start_i;
  assign en  = (state_q == ST_SCAN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mask_q  <= '0;
      gen_q   <= 1'b0;
      done_q  <= 1'b0;
      start_q <= '0;
      width_q <= '0;
      score_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mask_q  <= mask_i;
          gen_q   <= gen_sel_i;
          cnt_q   <= '0;
          state_q <= ST_SCAN;
        end
        ST_SCAN: begin
          // shift keeps the tap select a single flop instead of a wide mux
          mask_q <= mask_q >> 1;
          cnt_q  <= cnt_q + IDX_W'(1);
          if (cnt_q == LAST_IDX) state_q <= ST_FIN;
        end
        ST_FIN: begin
          start_q <= best_start;
          width_q <= calc_width;
          score_q <= calc_score;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  rlq_run_tracker #(.MASK_W(MASK_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_run (
    .clk_i, .rst_ni, .clr_i(clr), .en_i(en), .bit_i(mask_q[0]), .idx_i(cnt_q),
    .best_start_o(best_start), .best_len_o(best_len)
  );

  rlq_span_stats #(.MASK_W(MASK_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_span (
    .clk_i, .rst_ni, .clr_i(clr), .en_i(en), .bit_i(mask_q[0]), .idx_i(cnt_q),
    .any_o(any), .lo_o(lo), .hi_o(hi), .pop_o(pop)
  );

  rlq_score_calc #(
    .MASK_W(MASK_W), .IDX_W(IDX_W), .LEN_W(LEN_W), .RANGE_BITS(RANGE_BITS),
    .SCORE_W(SCORE_W), .NARROW_MIN(NARROW_MIN), .LIMIT_G0(LIMIT_G0),
    .LIMIT_G1(LIMIT_G1), .W_BLANK(W_BLANK), .W_NARROW(W_NARROW),
    .W_BUBBLE(W_BUBBLE), .W_LONG(W_LONG), .W_TRAIL(W_TRAIL)
  ) u_calc (
    .any_i(any), .best_len_i(best_len), .lo_i(lo), .hi_i(hi), .pop_i(pop),
    .gen_sel_i(gen_q), .width_o(calc_width), .score_o(calc_score)
  );

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign win_start_o = start_q;
  assign win_width_o = width_q;
  assign score_o     = score_q;

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));

  assert_busy_start_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN && cnt_q != LAST_IDX && start_i)
      |=> (state_q == ST_SCAN && cnt_q == $past(cnt_q) + IDX_W'(1)));

  assert_blank_score_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && win_width_o == '0) |-> (score_o == SCORE_W'(W_BLANK) && win_start_o == '0));

  assert_narrow_floor_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && win_width_o != '0 && win_width_o < RANGE_BITS'(NARROW_MIN))
      |-> (score_o >= SCORE_W'(W_NARROW * NARROW_MIN) - SCORE_W'(W_NARROW) * SCORE_W'(win_width_o)));
endmodule

// File: tb/sim_rl_window_scorer.sv
module sim_rl_window_scorer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] mask = '0;
  logic        gen = 1'b0;
  logic        busy, done;
  logic [5:0]  wstart, wwidth;
  logic [7:0]  score;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rl_window_scorer u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mask_i(mask), .gen_sel_i(gen),
    .busy_o(busy), .done_o(done), .win_start_o(wstart), .win_width_o(wwidth),
    .score_o(score)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] m, input bit g,
                                output int st, output int wd, output int sc);
    int best = 0, bst = 0, lo = -1, hi = -1, pop = 0, bub, lim, acc;
    for (int s = 0; s < 64; s++) begin
      if (m[s] && (s == 0 || !m[s-1])) begin
        int len = 0;
        for (int k = s; k < 64 && m[k]; k++) len++;
        if (len > best) begin best = len; bst = s; end
      end
      if (m[s]) begin
        if (lo < 0) lo = s;
        hi = s;
        pop++;
      end
    end
    st = bst;
    wd = (best > 63) ? 63 : best;
    lim = g ? 5 : 7;
    if (pop == 0) begin
      st = 0; wd = 0; acc = 100;
    end else begin
      bub = (hi - lo + 1) - pop;
      acc = 11 * bub;
      if (wd < 4) acc += 6 * (4 - wd);
      if (wd > lim) begin
        acc += 12;
        if (bub == 0) acc += 5 * (wd - lim);
      end
    end
    sc = (acc > 255) ? 255 : acc;
  endfunction

  task automatic run_one(input logic [63:0] m, input bit g, input string tag, input bit poke);
    int est, ewd, esc, lat;
    model(m, g, est, ewd, esc);
    @(negedge clk);
    start = 1'b1; mask = m; gen = g;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    check(busy == 1'b1, "R2 busy", busy, 1);
    while (!done && lat < 200) begin
      if (poke && lat == 10) begin start = 1'b1; mask = ~m; gen = ~g; end
      if (poke && lat == 11) start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check(lat == 66, "R2 latency", lat, 66);
    check(wstart == est[5:0], {tag, " R4 start"}, wstart, est);
    check(wwidth == ewd[5:0], {tag, " R4 width"}, wwidth, ewd);
    check(score == esc[7:0], {tag, " score"}, score, esc);
    @(negedge clk);
    check(done == 1'b0, "R2 pulse", done, 0);
    check(busy == 1'b0, "R3 idle after result", busy, 0);
  endtask

  initial begin
    logic [63:0] r;
    int seed_dummy;
    seed_dummy = $urandom(32'd51423);
    repeat (3) @(negedge clk);
    check(done == 0 && busy == 0, "R1 ctl", {done, busy}, 0);
    check(wstart == 0 && wwidth == 0 && score == 0, "R1 data", score, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_one(64'h0, 1'b0, "R5 blank", 1'b0);
    run_one(64'h0000_0000_0000_03C0, 1'b0, "R4 clean", 1'b0);
    run_one(64'h0000_0000_0000_0F0F, 1'b0, "R4 tie R7", 1'b0);
    run_one(64'h0000_0000_0000_0001, 1'b0, "R6 narrow", 1'b0);
    run_one(64'h0000_0000_0000_0060, 1'b1, "R6 narrow2", 1'b0);
    run_one(64'h0000_0000_0000_03F0, 1'b0, "R8 gen0", 1'b0);
    run_one(64'h0000_0000_0000_03F0, 1'b1, "R8 R9 gen1", 1'b0);
    run_one(64'h0000_0000_0000_1DF0, 1'b1, "R8 R7 no trail", 1'b0);
    run_one(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R4 cap R10", 1'b0);
    run_one(64'h8000_0000_0000_0001, 1'b0, "R10 sat", 1'b0);
    run_one(64'h0000_0000_00F0_0000, 1'b0, "R3 poke", 1'b1);
    run_one(64'h0000_00FF_FF00_0000, 1'b1, "R3 poke2", 1'b1);

    for (int i = 0; i < 150; i++) begin
      int kind = $urandom % 3;
      int pos = $urandom % 64;
      int len = 1 + ($urandom % 20);
      r = '0;
      if (kind == 0) r = {$urandom, $urandom};
      else begin
        for (int k = 0; k < len; k++) if (pos + k < 64) r[pos + k] = 1'b1;
        if (kind == 2) for (int k = 0; k < 3; k++) r[$urandom % 64] = 1'b1;
      end
      run_one(r, bit'($urandom % 2), "R7 rand", bit'(i % 17 == 0));
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule